// File: doc/BRIEF.md
# Pipeline Drain and Stall Controller

This block is the hazard-control unit of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). It looks at the word sitting in fetch, a flag from the environment that marks a substituted library call, the valid bit of every later stage and a flag saying a branch is being resolved in execute. From these it drives the program-counter hold, the kill that turns the fetch/decode register into a bubble, a one-cycle handshake that hands a call to the environment, a per-cycle lost-cycle pulse with its cause, and the operand-forwarding selects for both execute operands.

A system call or substituted call reaches the register file from outside the pipeline. The fetch stage therefore keeps the call where it is and feeds bubbles forward until every older instruction has written back. It then lets the call go and raises the handshake for one cycle. A branch resolved in execute costs exactly one bubble, placed behind its delay-slot instruction. A load never stalls: the load delay slot lets the next instruction read the old value, so a load still in the memory stage is never forwarded.

Top module: `hzd_ctrl`

## Requirements
- R1: A valid fetch word equal to 32'h0000000C, or a valid fetch word with `lib_call` high, is a call. A call is discarded when `br_in_ex` is high, and also in the cycle just after a release.
- R2: While a call is present and any of `id_valid`, `ex_valid`, `mem_valid` is high, the outputs `pc_hold`, `ifid_kill` and `stall_event` are all 1 and `stall_cause` is 1 (call). When WB_WRITE_FIRST is 0, `wb_valid` also counts as older work.
- R3: When a call is present and no older work remains, `call_go` is 1 for that cycle, and `pc_hold`, `ifid_kill` and `stall_event` are 0.
- R4: In the cycle after `call_go`, a call word still in fetch gives no hold, no kill and no second `call_go`.
- R5: When `br_in_ex` is high, `ifid_kill` and `stall_event` are 1, `stall_cause` is 0 (branch), and `pc_hold` and `call_go` are 0, whatever the fetch word is.
- R6: With no call and no branch, `pc_hold`, `ifid_kill`, `stall_event` and `call_go` are 0, whatever loads and register dependences are in flight.
- R7: A forward select of 2'b01 picks the memory-stage result. It is chosen when `mem_valid`, `mem_wen` and not `mem_is_load` hold, `mem_dst` is nonzero and equal to the operand's source register. 2'b00 means the register file.
- R8: A forward select of 2'b10 picks the write-back result. It is chosen only when R7 does not apply and `wb_valid`, `wb_wen` hold, and `wb_dst` is nonzero and matches, so the younger producer wins.
- R9: A load in the memory stage is never forwarded. A matching older write-back producer is forwarded instead, and otherwise the register file is used.
- R10: `stall_event` is a single bit, so a cycle that is both a branch bubble and a call hold is counted once. In that cycle the branch is the cause.
- R11: With WB_WRITE_FIRST at 0, a call waits while `wb_valid` is high. With the default of 1, it is released in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_valid | input | 1 | Fetch word is valid |
| if_word | input | 32 | Word currently in fetch |
| lib_call | input | 1 | Environment marks fetch word as substituted call |
| id_valid | input | 1 | Decode stage holds an instruction |
| ex_valid | input | 1 | Execute stage holds an instruction |
| mem_valid | input | 1 | Memory stage holds an instruction |
| wb_valid | input | 1 | Write-back stage holds an instruction |
| br_in_ex | input | 1 | Branch resolved in execute this cycle |
| ex_src_a | input | 5 | Execute operand A source register |
| ex_src_b | input | 5 | Execute operand B source register |
| mem_dst | input | 5 | Memory-stage destination register |
| mem_wen | input | 1 | Memory-stage register write enable |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_dst | input | 5 | Write-back destination register |
| wb_wen | input | 1 | Write-back register write enable |
| pc_hold | output | 1 | Keep program counter |
| ifid_kill | output | 1 | Load a bubble into fetch/decode register |
| call_go | output | 1 | Environment may now service the call |
| stall_event | output | 1 | This cycle is a lost cycle |
| stall_cause | output | 1 | 0 branch, 1 call drain |
| fwd_a | output | 2 | Operand A forward select |
| fwd_b | output | 2 | Operand B forward select |

## Verification
The bench builds two copies side by side. One uses the default WB_WRITE_FIRST of 1 and the other uses 0, so the same stimulus shows when a release coincides with a write-back and when it waits one more cycle. Register numbers are drawn from a narrow range including zero. This makes memory-stage and write-back producers collide often, covers the younger-wins and load-skip orderings, and shows that register 0 is never forwarded. Call words, substituted-call flags and branches overlap often enough to exercise the discard rule and the single count of an overlapped cycle.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_MEM = 2'b01,
      FWD_WB  = 2'b10
   } fwd_sel_e;

   typedef enum logic {
      CAUSE_BRANCH = 1'b0,
      CAUSE_CALL   = 1'b1
   } stall_cause_e;
endpackage

// File: rtl/hzd_call_drain.sv
module hzd_call_drain #(
   parameter int          XLEN           = 32,
   parameter logic [31:0] CALL_WORD      = 32'h0000000C,
   parameter bit          WB_WRITE_FIRST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            if_valid,
   input  logic [XLEN-1:0] if_word,
   input  logic            lib_call,
   input  logic            id_valid,
   input  logic            ex_valid,
   input  logic            mem_valid,
   input  logic            wb_valid,
   input  logic            squash,
   output logic            hold,
   output logic            go
);
   localparam logic [XLEN-1:0] CallPattern = XLEN'(CALL_WORD);

   logic busy;
   logic go_q;
   logic is_call;
   logic present;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("hzd_call_drain: XLEN must be at least 32");
      end
      if (WB_WRITE_FIRST) begin : g_wb_early
         assign busy = id_valid | ex_valid | mem_valid;
      end else begin : g_wb_late
         assign busy = id_valid | ex_valid | mem_valid | wb_valid;
      end
   endgenerate

   assign is_call = if_valid & ((if_word == CallPattern) | lib_call);
   assign present = is_call & ~squash & ~go_q;
   assign hold    = present & busy;
   assign go      = present & ~busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) go_q <= 1'b0;
      else        go_q <= go;
   end
endmodule

// File: rtl/hzd_fwd_unit.sv
module hzd_fwd_unit
   import hzd_pkg::*;
#(
   parameter int REG_AW = 5,
   parameter int N_OPS  = 2
) (
   input  logic [N_OPS-1:0][REG_AW-1:0] src,
   input  logic                         mem_valid,
   input  logic                         mem_wen,
   input  logic                         mem_is_load,
   input  logic [REG_AW-1:0]            mem_dst,
   input  logic                         wb_valid,
   input  logic                         wb_wen,
   input  logic [REG_AW-1:0]            wb_dst,
   output fwd_sel_e [N_OPS-1:0]         sel
);
   logic mem_ok;
   logic wb_ok;

   generate
      if (REG_AW < 1) begin : g_bad_aw
         $error("hzd_fwd_unit: REG_AW must be positive");
      end
      if (N_OPS < 1) begin : g_bad_ops
         $error("hzd_fwd_unit: N_OPS must be positive");
      end
   endgenerate

   assign mem_ok = mem_valid & mem_wen & ~mem_is_load & (mem_dst != '0);
   assign wb_ok  = wb_valid & wb_wen & (wb_dst != '0);

   generate
      for (genvar i = 0; i < N_OPS; i++) begin : g_op
         always_comb begin
            if (mem_ok && (mem_dst == src[i]))     sel[i] = FWD_MEM;
            else if (wb_ok && (wb_dst == src[i]))  sel[i] = FWD_WB;
            else                                   sel[i] = FWD_RF;
         end
      end
   endgenerate
endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
   import hzd_pkg::*;
#(
   parameter int          XLEN           = 32,
   parameter int          REG_AW         = 5,
   parameter logic [31:0] CALL_WORD      = 32'h0000000C,
   parameter bit          WB_WRITE_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              if_valid,
   input  logic [XLEN-1:0]   if_word,
   input  logic              lib_call,
   input  logic              id_valid,
   input  logic              ex_valid,
   input  logic              mem_valid,
   input  logic              wb_valid,
   input  logic              br_in_ex,
   input  logic [REG_AW-1:0] ex_src_a,
   input  logic [REG_AW-1:0] ex_src_b,
   input  logic [REG_AW-1:0] mem_dst,
   input  logic              mem_wen,
   input  logic              mem_is_load,
   input  logic [REG_AW-1:0] wb_dst,
   input  logic              wb_wen,
   output logic              pc_hold,
   output logic              ifid_kill,
   output logic              call_go,
   output logic              stall_event,
   output logic              stall_cause,
   output logic [1:0]        fwd_a,
   output logic [1:0]        fwd_b
);
   localparam int NumOps = 2;

   logic                         drain_hold;
   logic                         drain_go;
   logic [NumOps-1:0][REG_AW-1:0] op_src;
   fwd_sel_e [NumOps-1:0]         op_sel;
   stall_cause_e                  cause;

   hzd_call_drain #(
      .XLEN           (XLEN),
      .CALL_WORD      (CALL_WORD),
      .WB_WRITE_FIRST (WB_WRITE_FIRST)
   ) i_drain (
      .clk       (clk),
      .rst_n     (rst_n),
      .if_valid  (if_valid),
      .if_word   (if_word),
      .lib_call  (lib_call),
      .id_valid  (id_valid),
      .ex_valid  (ex_valid),
      .mem_valid (mem_valid),
      .wb_valid  (wb_valid),
      .squash    (br_in_ex),
      .hold      (drain_hold),
      .go        (drain_go)
   );

   assign op_src[0] = ex_src_a;
   assign op_src[1] = ex_src_b;

   hzd_fwd_unit #(
      .REG_AW (REG_AW),
      .N_OPS  (NumOps)
   ) i_fwd (
      .src         (op_src),
      .mem_valid   (mem_valid),
      .mem_wen     (mem_wen),
      .mem_is_load (mem_is_load),
      .mem_dst     (mem_dst),
      .wb_valid    (wb_valid),
      .wb_wen      (wb_wen),
      .wb_dst      (wb_dst),
      .sel         (op_sel)
   );

   assign cause       = drain_hold ? CAUSE_CALL : CAUSE_BRANCH;
   assign pc_hold     = drain_hold;
   assign ifid_kill   = drain_hold | br_in_ex;
   assign call_go     = drain_go;
   assign stall_event = drain_hold | br_in_ex;
   assign stall_cause = cause;
   assign fwd_a       = op_sel[0];
   assign fwd_b       = op_sel[1];
endmodule

// File: rtl/hzd_ctrl_chk.sv
module hzd_ctrl_chk #(
   parameter int XLEN           = 32,
   parameter int REG_AW         = 5,
   parameter bit WB_WRITE_FIRST = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              if_valid,
   input logic [XLEN-1:0]   if_word,
   input logic              lib_call,
   input logic              id_valid,
   input logic              ex_valid,
   input logic              mem_valid,
   input logic              wb_valid,
   input logic              br_in_ex,
   input logic [REG_AW-1:0] ex_src_a,
   input logic [REG_AW-1:0] ex_src_b,
   input logic [REG_AW-1:0] mem_dst,
   input logic              mem_wen,
   input logic              mem_is_load,
   input logic [REG_AW-1:0] wb_dst,
   input logic              wb_wen,
   input logic              pc_hold,
   input logic              ifid_kill,
   input logic              call_go,
   input logic              stall_event,
   input logic              stall_cause,
   input logic [1:0]        fwd_a,
   input logic [1:0]        fwd_b
);
   logic late_busy;
   assign late_busy = !WB_WRITE_FIRST && wb_valid;

   assert_hold_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pc_hold |-> (id_valid || ex_valid || mem_valid || late_busy) && stall_cause && ifid_kill);

   assert_go_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      call_go |-> !id_valid && !ex_valid && !mem_valid && !late_busy && !pc_hold);

   assert_go_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      call_go |=> !call_go);

   assert_branch_bubble_R5: assert property (@(posedge clk) disable iff (!rst_n)
      br_in_ex |-> ifid_kill && !pc_hold && !call_go && !stall_cause);

   assert_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!if_valid && !br_in_ex) |-> !pc_hold && !ifid_kill && !stall_event && !call_go);

   assert_fwd_mem_a_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_a == 2'b01) |-> mem_valid && mem_wen && (mem_dst == ex_src_a) && (mem_dst != '0));

   assert_fwd_wb_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (fwd_b == 2'b10) |-> wb_valid && wb_wen && (wb_dst == ex_src_b) && (wb_dst != '0));

   assert_no_load_fwd_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_is_load && (fwd_a == 2'b01 || fwd_b == 2'b01)) |-> 1'b0 == mem_valid);

   assert_event_once_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stall_event |-> ($countones({pc_hold, br_in_ex}) == 1) && !call_go);
endmodule

bind hzd_ctrl hzd_ctrl_chk #(
   .XLEN           (XLEN),
   .REG_AW         (REG_AW),
   .WB_WRITE_FIRST (WB_WRITE_FIRST)
) i_hzd_ctrl_chk (.*);

// File: tb/test_hzd_ctrl.sv
module test_hzd_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCYC       = 4000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        if_valid = 0, lib_call = 0, br_in_ex = 0;
   logic [31:0] if_word = '0;
   logic        id_valid = 0, ex_valid = 0, mem_valid = 0, wb_valid = 0;
   logic [4:0]  ex_src_a = '0, ex_src_b = '0, mem_dst = '0, wb_dst = '0;
   logic        mem_wen = 0, mem_is_load = 0, wb_wen = 0;

   logic       e_hold, e_kill, e_go, e_ev, e_cause;
   logic [1:0] e_fa, e_fb;
   logic       l_hold, l_kill, l_go, l_ev, l_cause;
   logic [1:0] l_fa, l_fb;

   int checks = 0;
   int fails  = 0;
   bit goq_e = 0, goq_l = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   hzd_ctrl i_hzd_ctrl (
      .clk, .rst_n, .if_valid, .if_word, .lib_call, .id_valid, .ex_valid,
      .mem_valid, .wb_valid, .br_in_ex, .ex_src_a, .ex_src_b, .mem_dst,
      .mem_wen, .mem_is_load, .wb_dst, .wb_wen,
      .pc_hold(e_hold), .ifid_kill(e_kill), .call_go(e_go),
      .stall_event(e_ev), .stall_cause(e_cause), .fwd_a(e_fa), .fwd_b(e_fb));

   hzd_ctrl #(.WB_WRITE_FIRST(1'b0)) i_hzd_ctrl_late (
      .clk, .rst_n, .if_valid, .if_word, .lib_call, .id_valid, .ex_valid,
      .mem_valid, .wb_valid, .br_in_ex, .ex_src_a, .ex_src_b, .mem_dst,
      .mem_wen, .mem_is_load, .wb_dst, .wb_wen,
      .pc_hold(l_hold), .ifid_kill(l_kill), .call_go(l_go),
      .stall_event(l_ev), .stall_cause(l_cause), .fwd_a(l_fa), .fwd_b(l_fb));

   task automatic chk(input string tag, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int ref_fwd(input logic [4:0] s);
      if (mem_valid && mem_wen && !mem_is_load && mem_dst != 0 && mem_dst == s) return 1;
      if (wb_valid && wb_wen && wb_dst != 0 && wb_dst == s) return 2;
      return 0;
   endfunction

   function automatic string fwd_tag(input logic [4:0] s);
      if (mem_valid && mem_is_load && mem_dst == s) return "R9";
      if (wb_valid && wb_wen && wb_dst == s) return "R8";
      return "R7";
   endfunction

   // Compare one copy against the behavioural expectation; returns expected go.
   task automatic check_copy(input bit late, input bit goq,
                             input logic hold, input logic kill, input logic go,
                             input logic ev, input logic cause, output bit exp_go);
      bit is_call, present, busy, xh;
      string tag;
      is_call = if_valid && (if_word == 32'h0000000C || lib_call);
      present = is_call && !br_in_ex && !goq;
      busy    = id_valid || ex_valid || mem_valid || (late && wb_valid);
      xh      = present && busy;
      exp_go  = present && !busy;
      if (br_in_ex)               tag = is_call ? "R10" : "R5";
      else if (is_call && goq)    tag = "R4";
      else if (present && late && wb_valid && !(id_valid || ex_valid || mem_valid)) tag = "R11";
      else if (xh)                tag = "R2";
      else if (exp_go)            tag = "R3";
      else                        tag = "R6";
      chk(tag, "pc_hold",     int'(hold),  int'(xh));
      chk(tag, "ifid_kill",   int'(kill),  int'(xh || br_in_ex));
      chk(tag, "call_go",     int'(go),    int'(exp_go));
      chk(tag, "stall_event", int'(ev),    int'(xh || br_in_ex));
      if (xh || br_in_ex) chk(tag, "stall_cause", int'(cause), int'(xh));
      if (present) chk("R1", "call seen", int'(hold || go), 1);
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 200000);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : stim
      bit ng_e, ng_l;
      repeat (3) @(posedge clk);
      #1;
      chk("R6", "reset call_go",  int'(e_go),   0);
      chk("R6", "reset pc_hold",  int'(e_hold), 0);
      chk("R6", "reset stall",    int'(e_ev),   0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int c = 0; c < NCYC; c++) begin
         @(negedge clk);
         if_valid    = ($urandom_range(0, 4) != 0);
         if_word     = ($urandom_range(0, 3) == 0) ? 32'h0000000C : $urandom;
         lib_call    = ($urandom_range(0, 7) == 0);
         br_in_ex    = ($urandom_range(0, 5) == 0);
         id_valid    = ($urandom_range(0, 2) == 0);
         ex_valid    = ($urandom_range(0, 2) == 0);
         mem_valid   = ($urandom_range(0, 1) == 0);
         wb_valid    = ($urandom_range(0, 1) == 0);
         mem_wen     = ($urandom_range(0, 3) != 0);
         wb_wen      = ($urandom_range(0, 3) != 0);
         mem_is_load = ($urandom_range(0, 3) == 0);
         ex_src_a    = 5'($urandom_range(0, 3));
         ex_src_b    = 5'($urandom_range(0, 3));
         mem_dst     = 5'($urandom_range(0, 3));
         wb_dst      = 5'($urandom_range(0, 3));
         #(CLK_PERIOD/4);
         check_copy(1'b0, goq_e, e_hold, e_kill, e_go, e_ev, e_cause, ng_e);
         check_copy(1'b1, goq_l, l_hold, l_kill, l_go, l_ev, l_cause, ng_l);
         chk(fwd_tag(ex_src_a), "fwd_a", int'(e_fa), ref_fwd(ex_src_a));
         chk(fwd_tag(ex_src_b), "fwd_b", int'(e_fb), ref_fwd(ex_src_b));
         chk("R11", "late fwd_a", int'(l_fa), ref_fwd(ex_src_a));
         @(posedge clk);
         goq_e = ng_e;
         goq_l = ng_l;
      end
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule